// File: doc/BRIEF.md
# Jump-and-Link Operand Forwarding and Link Result Path

This block is a slice of a five-stage integer pipeline. It covers three things. It resolves the Rs operand in the decode (ID) stage. It detects when an Rs read depends on a load that is still in execute (EX). It holds the EX-stage register, which drives the result and destination for the instruction in EX.

The ID operand mux picks a register value only. That value comes from the register file or from one of the three later stages, and the mux never picks a link address. Link addresses are put onto the result path in EX, using the restart PC that travels with each instruction. This split lets a register-indirect call do two things in the same instruction: read its target through forwarding, and write its return address. A linking instruction can never sit in a delay slot, so its restart PC is always its own PC.

The EX stage of the slice is internal, and it is the highest-priority forwarding source. The MEM and WB forwarding sources come in as inputs.

Top module: `jlink_fwd_slice`

## Requirements
- R1: After reset, and before any instruction is accepted, `ex_we`, `ex_is_load` and `stall` are 0.
- R2: `id_rs_value` takes the value from the newest matching producer. A producer matches when its write enable is 1 and its destination equals `id_rs`. EX has priority over MEM, MEM over WB, and WB over `rf_rs_data`.
- R3: When `id_rs` is 0, `id_rs_value` is 0 whatever the register file or any forwarding source holds.
- R4: Opcodes are 0 NOP, 1 ADDI, 2 LOAD, 3 JR, 4 JALR, 5 JAL and 6 BAL. A valid ADDI, LOAD, JR or JALR whose nonzero `id_rs` equals the destination of a writing LOAD in EX raises `stall`. In the cycle after a stall, EX holds a bubble (`ex_we` is 0).
- R5: JAL (5) and BAL (6) never raise `stall`, even when their `id_rs` field matches a load in EX.
- R6: `id_jump` is 1 for a valid, unstalled JR (3) or JALR (4), and `id_jump_target` then equals `id_rs_value`.
- R7: One cycle after a JAL, BAL or JALR is accepted, `ex_result` equals its `id_restart_pc` plus 8.
- R8: JAL and BAL write register 31. JALR writes its `id_rd`. JR writes nothing (`ex_we` is 0).
- R9: A JALR whose Rs comes through forwarding jumps to the forwarded value and still writes its link value in EX.
- R10: ADDI (1) and LOAD (2) give `ex_result` = resolved Rs + `id_imm` and write `id_rd`. Only LOAD sets `ex_is_load`.
- R11: An instruction whose destination is register 0 leaves `ex_we` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | The ID slot holds an instruction |
| id_op | input | 3 | Operation code (see R4) |
| id_rs | input | 5 | Rs register index |
| id_rd | input | 5 | Destination index for ADDI, LOAD and JALR |
| id_imm | input | 32 | Immediate for ADDI and LOAD |
| id_restart_pc | input | 32 | Restart PC of the ID instruction |
| rf_rs_data | input | 32 | Register-file read data for Rs |
| mem_we | input | 1 | The MEM-stage instruction writes a register |
| mem_dest | input | 5 | MEM-stage destination |
| mem_result | input | 32 | MEM-stage result (load data for loads) |
| wb_we | input | 1 | The WB-stage instruction writes a register |
| wb_dest | input | 5 | WB-stage destination |
| wb_result | input | 32 | WB-stage result |
| id_rs_value | output | 32 | Resolved Rs operand |
| id_jump | output | 1 | A register-indirect jump is taken this cycle |
| id_jump_target | output | 32 | Jump target |
| stall | output | 1 | Hold the PC and the IF/ID register |
| ex_we | output | 1 | The EX instruction writes a register |
| ex_dest | output | 5 | EX destination |
| ex_result | output | 32 | EX result, with the link value put in here |
| ex_is_load | output | 1 | The EX instruction is a load |

## Verification
The central case is a load into a register followed at once by a JALR through that register. A design that shared the operand mux with link injection would jump to the link address instead of the loaded value, or would drop the jump. A design that missed the hazard would jump to a stale register-file value. The bench also sets every forwarding stage to match at once, to expose a wrong priority order. It points Rs at register 0 while a source claims to write it, and gives a JAL or BAL an Rs field that matches a pending load; a design that wrongly decodes Rs use for these would stall for no reason. Writes of JR and of instructions whose destination is register 0 must not appear.

// File: rtl/jlf_pkg.sv
package jlf_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ADDI = 3'd1,
        OP_LOAD = 3'd2,
        OP_JR   = 3'd3,
        OP_JALR = 3'd4,
        OP_JAL  = 3'd5,
        OP_BAL  = 3'd6
    } op_e;

    function automatic logic op_reads_rs(op_e op);
        return (op == OP_ADDI) || (op == OP_LOAD) || (op == OP_JR) || (op == OP_JALR);
    endfunction

    function automatic logic op_links(op_e op);
        return (op == OP_JAL) || (op == OP_BAL) || (op == OP_JALR);
    endfunction

    function automatic logic op_reg_jump(op_e op);
        return (op == OP_JR) || (op == OP_JALR);
    endfunction

endpackage

// File: rtl/jlf_rs_fwd.sv
module jlf_rs_fwd #(
    parameter int XLEN = 32,
    parameter int RIDX = 5,
    parameter int NSRC = 3
) (
    input  logic [RIDX-1:0]           rs_i,
    input  logic [XLEN-1:0]           rf_data_i,
    // index 0 is oldest (lowest priority), NSRC-1 newest
    input  logic [NSRC-1:0]           src_we_i,
    input  logic [NSRC-1:0][RIDX-1:0] src_dest_i,
    input  logic [NSRC-1:0][XLEN-1:0] src_data_i,
    output logic [XLEN-1:0]           value_o
);

    logic rs_is_zero;
    assign rs_is_zero = (rs_i == '0);

    always_comb begin
        value_o = rs_is_zero ? '0 : rf_data_i;
        for (int i = 0; i < NSRC; i++) begin
            if (!rs_is_zero && src_we_i[i] && (src_dest_i[i] == rs_i)) begin
                value_o = src_data_i[i];
            end
        end
    end

    always_comb begin
        p_zero_reads_zero_r3: assert (!rs_is_zero || (value_o == '0));
    end

endmodule

// File: rtl/jlf_hazard.sv
module jlf_hazard #(
    parameter int RIDX = 5
) (
    input  logic              id_valid_i,
    input  jlf_pkg::op_e      id_op_i,
    input  logic [RIDX-1:0]   id_rs_i,
    input  logic              ex_we_i,
    input  logic              ex_is_load_i,
    input  logic [RIDX-1:0]   ex_dest_i,
    output logic              stall_o
);
    import jlf_pkg::*;

    logic uses_rs;
    logic dep;

    assign uses_rs = id_valid_i && op_reads_rs(id_op_i) && (id_rs_i != '0);
    assign dep     = ex_we_i && ex_is_load_i && (ex_dest_i == id_rs_i);
    assign stall_o = uses_rs && dep;

    always_comb begin
        p_link_no_stall_r5: assert (!((id_op_i == OP_JAL || id_op_i == OP_BAL) && stall_o));
    end

endmodule

// File: rtl/jlf_ex_stage.sv
module jlf_ex_stage #(
    parameter int XLEN        = 32,
    parameter int RIDX        = 5,
    parameter int LINK_REG    = 31,
    parameter int LINK_OFFSET = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall_i,
    input  logic            id_valid_i,
    input  jlf_pkg::op_e    id_op_i,
    input  logic [RIDX-1:0] id_rd_i,
    input  logic [XLEN-1:0] id_rs_value_i,
    input  logic [XLEN-1:0] id_imm_i,
    input  logic [XLEN-1:0] id_restart_pc_i,
    output logic            we_o,
    output logic [RIDX-1:0] dest_o,
    output logic [XLEN-1:0] result_o,
    output logic            is_load_o
);
    import jlf_pkg::*;

    localparam logic [RIDX-1:0] LinkIdx = RIDX'(LINK_REG);
    localparam logic [XLEN-1:0] LinkAdd = XLEN'(LINK_OFFSET);

    typedef struct packed {
        logic            valid;
        op_e             op;
        logic [RIDX-1:0] rd;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] imm;
        logic [XLEN-1:0] pc;
    } ex_state_t;

    ex_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (id_valid_i && !stall_i) begin
            state_d.valid = 1'b1;
            state_d.op    = id_op_i;
            state_d.rd    = id_rd_i;
            state_d.opa   = id_rs_value_i;
            state_d.imm   = id_imm_i;
            state_d.pc    = id_restart_pc_i;
        end else begin
            state_d.valid = 1'b0;
            state_d.op    = OP_NOP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{valid: 1'b0, op: OP_NOP, rd: '0, opa: '0, imm: '0, pc: '0};
        end else begin
            state_q <= state_d;
        end
    end

    // link injection happens here, in EX, not in the ID operand mux
    logic writes;
    always_comb begin
        writes    = 1'b0;
        dest_o    = state_q.rd;
        result_o  = state_q.opa + state_q.imm;
        is_load_o = state_q.valid && (state_q.op == OP_LOAD);
        case (state_q.op)
            OP_ADDI, OP_LOAD: writes = 1'b1;
            OP_JALR: begin
                writes   = 1'b1;
                result_o = state_q.pc + LinkAdd;
            end
            OP_JAL, OP_BAL: begin
                writes   = 1'b1;
                dest_o   = LinkIdx;
                result_o = state_q.pc + LinkAdd;
            end
            default: writes = 1'b0;
        endcase
        we_o = state_q.valid && writes && (dest_o != '0);
    end

    p_bubble_after_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> !we_o);

    p_link_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid_i && !stall_i && op_links(id_op_i)) |=>
            (result_o == $past(id_restart_pc_i) + LinkAdd));

    p_no_write_r0_r11: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> (dest_o != '0));

endmodule

// File: rtl/jlink_fwd_slice.sv
module jlink_fwd_slice #(
    parameter int XLEN        = 32,
    parameter int RIDX        = 5,
    parameter int LINK_REG    = 31,
    parameter int LINK_OFFSET = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_valid,
    input  logic [2:0]      id_op,
    input  logic [RIDX-1:0] id_rs,
    input  logic [RIDX-1:0] id_rd,
    input  logic [XLEN-1:0] id_imm,
    input  logic [XLEN-1:0] id_restart_pc,
    input  logic [XLEN-1:0] rf_rs_data,
    input  logic            mem_we,
    input  logic [RIDX-1:0] mem_dest,
    input  logic [XLEN-1:0] mem_result,
    input  logic            wb_we,
    input  logic [RIDX-1:0] wb_dest,
    input  logic [XLEN-1:0] wb_result,
    output logic [XLEN-1:0] id_rs_value,
    output logic            id_jump,
    output logic [XLEN-1:0] id_jump_target,
    output logic            stall,
    output logic            ex_we,
    output logic [RIDX-1:0] ex_dest,
    output logic [XLEN-1:0] ex_result,
    output logic            ex_is_load
);
    import jlf_pkg::*;

    localparam int NSRC = 3;

    op_e op;
    assign op = op_e'(id_op);

    logic [NSRC-1:0]           src_we;
    logic [NSRC-1:0][RIDX-1:0] src_dest;
    logic [NSRC-1:0][XLEN-1:0] src_data;

    assign src_we   = {ex_we,     mem_we,     wb_we};
    assign src_dest = {ex_dest,   mem_dest,   wb_dest};
    assign src_data = {ex_result, mem_result, wb_result};

    jlf_rs_fwd #(.XLEN(XLEN), .RIDX(RIDX), .NSRC(NSRC)) u_fwd (
        .rs_i       (id_rs),
        .rf_data_i  (rf_rs_data),
        .src_we_i   (src_we),
        .src_dest_i (src_dest),
        .src_data_i (src_data),
        .value_o    (id_rs_value)
    );

    jlf_hazard #(.RIDX(RIDX)) u_haz (
        .id_valid_i   (id_valid),
        .id_op_i      (op),
        .id_rs_i      (id_rs),
        .ex_we_i      (ex_we),
        .ex_is_load_i (ex_is_load),
        .ex_dest_i    (ex_dest),
        .stall_o      (stall)
    );

    jlf_ex_stage #(.XLEN(XLEN), .RIDX(RIDX), .LINK_REG(LINK_REG),
                   .LINK_OFFSET(LINK_OFFSET)) u_ex (
        .clk             (clk),
        .rst_n           (rst_n),
        .stall_i         (stall),
        .id_valid_i      (id_valid),
        .id_op_i         (op),
        .id_rd_i         (id_rd),
        .id_rs_value_i   (id_rs_value),
        .id_imm_i        (id_imm),
        .id_restart_pc_i (id_restart_pc),
        .we_o            (ex_we),
        .dest_o          (ex_dest),
        .result_o        (ex_result),
        .is_load_o       (ex_is_load)
    );

    assign id_jump        = id_valid && !stall && op_reg_jump(op);
    assign id_jump_target = id_rs_value;

    always_comb begin
        p_jump_not_stalled_r6: assert (!(id_jump && stall));
    end

endmodule

// File: tb/jlink_fwd_slice_bench.sv
`timescale 1ns/1ps
module jlink_fwd_slice_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_valid = 1'b0;
    logic [2:0]  id_op = 3'd0;
    logic [4:0]  id_rs = '0, id_rd = '0;
    logic [31:0] id_imm = '0, id_restart_pc = '0, rf_rs_data = '0;
    logic        mem_we = 1'b0, wb_we = 1'b0;
    logic [4:0]  mem_dest = '0, wb_dest = '0;
    logic [31:0] mem_result = '0, wb_result = '0;
    logic [31:0] id_rs_value, id_jump_target, ex_result;
    logic        id_jump, stall, ex_we, ex_is_load;
    logic [4:0]  ex_dest;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    jlink_fwd_slice u_jlink_fwd_slice (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_op(id_op),
        .id_rs(id_rs), .id_rd(id_rd), .id_imm(id_imm),
        .id_restart_pc(id_restart_pc), .rf_rs_data(rf_rs_data),
        .mem_we(mem_we), .mem_dest(mem_dest), .mem_result(mem_result),
        .wb_we(wb_we), .wb_dest(wb_dest), .wb_result(wb_result),
        .id_rs_value(id_rs_value), .id_jump(id_jump),
        .id_jump_target(id_jump_target), .stall(stall), .ex_we(ex_we),
        .ex_dest(ex_dest), .ex_result(ex_result), .ex_is_load(ex_is_load)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [2:0] op, input logic [4:0] rs,
                         input logic [4:0] rd, input logic [31:0] imm,
                         input logic [31:0] pc, input logic [31:0] rf);
        @(negedge clk);
        id_valid = v; id_op = op; id_rs = rs; id_rd = rd;
        id_imm = imm; id_restart_pc = pc; rf_rs_data = rf;
        #1;
    endtask

    task automatic edge_then_sample();
        @(posedge clk); #1;
    endtask

    task automatic clear_srcs();
        mem_we = 0; mem_dest = 0; mem_result = 0;
        wb_we = 0; wb_dest = 0; wb_result = 0;
    endtask

    task automatic t_reset();
        chk("R1 ex_we", {31'b0, ex_we}, 32'd0);
        chk("R1 ex_is_load", {31'b0, ex_is_load}, 32'd0);
        chk("R1 stall", {31'b0, stall}, 32'd0);
    endtask

    task automatic t_priority();
        clear_srcs();
        issue(1, 3'd0, 5'd4, 5'd0, 0, 0, 32'h111);
        chk("R2 regfile", id_rs_value, 32'h111);
        wb_we = 1; wb_dest = 4; wb_result = 32'h444; #1;
        chk("R2 wb", id_rs_value, 32'h444);
        mem_we = 1; mem_dest = 4; mem_result = 32'h555; #1;
        chk("R2 mem over wb", id_rs_value, 32'h555);
        issue(1, 3'd1, 5'd0, 5'd4, 32'h777, 0, 32'h0);
        edge_then_sample();
        chk("R10 addi result", ex_result, 32'h777);
        chk("R10 addi dest", {27'b0, ex_dest}, 32'd4);
        chk("R10 addi no load", {31'b0, ex_is_load}, 32'd0);
        id_op = 3'd0; id_rs = 4; #1;
        chk("R2 ex over mem", id_rs_value, 32'h777);
        clear_srcs();
    endtask

    task automatic t_zero();
        issue(1, 3'd0, 5'd0, 5'd0, 0, 0, 32'hDEAD);
        wb_we = 1; wb_dest = 0; wb_result = 32'hBEEF;
        mem_we = 1; mem_dest = 0; mem_result = 32'hCAFE; #1;
        chk("R3 r0 reads zero", id_rs_value, 32'h0);
        clear_srcs();
    endtask

    task automatic t_load_jalr();
        clear_srcs();
        issue(1, 3'd2, 5'd0, 5'd2, 32'h100, 32'h5b4, 0);
        edge_then_sample();
        chk("R10 load flag", {31'b0, ex_is_load}, 32'd1);
        chk("R10 load addr", ex_result, 32'h100);
        issue(1, 3'd4, 5'd2, 5'd5, 0, 32'h5bc, 32'h1234);
        chk("R4 stall on load-use", {31'b0, stall}, 32'd1);
        chk("R6 no jump while stalled", {31'b0, id_jump}, 32'd0);
        edge_then_sample();
        chk("R4 bubble", {31'b0, ex_we}, 32'd0);
        mem_we = 1; mem_dest = 2; mem_result = 32'h4000; #1;
        chk("R4 stall released", {31'b0, stall}, 32'd0);
        chk("R9 jump taken", {31'b0, id_jump}, 32'd1);
        chk("R9 target is loaded value", id_jump_target, 32'h4000);
        edge_then_sample();
        chk("R9 link written", {31'b0, ex_we}, 32'd1);
        chk("R8 jalr dest rd", {27'b0, ex_dest}, 32'd5);
        chk("R7 jalr link", ex_result, 32'h5c4);
        clear_srcs();
    endtask

    task automatic t_jal_bal();
        issue(1, 3'd2, 5'd0, 5'd3, 32'h10, 0, 0);
        edge_then_sample();
        issue(1, 3'd5, 5'd3, 5'd0, 0, 32'h200, 0);
        chk("R5 jal no stall", {31'b0, stall}, 32'd0);
        chk("R6 jal not reg jump", {31'b0, id_jump}, 32'd0);
        edge_then_sample();
        chk("R8 jal dest 31", {27'b0, ex_dest}, 32'd31);
        chk("R7 jal link", ex_result, 32'h208);
        issue(1, 3'd2, 5'd0, 5'd3, 32'h10, 0, 0);
        edge_then_sample();
        issue(1, 3'd6, 5'd3, 5'd0, 0, 32'h300, 0);
        chk("R5 bal no stall", {31'b0, stall}, 32'd0);
        edge_then_sample();
        chk("R8 bal dest 31", {27'b0, ex_dest}, 32'd31);
        chk("R7 bal link", ex_result, 32'h308);
        chk("R8 bal writes", {31'b0, ex_we}, 32'd1);
    endtask

    task automatic t_jr_and_r0();
        issue(1, 3'd3, 5'd9, 5'd7, 0, 32'h80, 32'h900);
        chk("R6 jr jump", {31'b0, id_jump}, 32'd1);
        chk("R6 jr target", id_jump_target, 32'h900);
        edge_then_sample();
        chk("R8 jr no write", {31'b0, ex_we}, 32'd0);
        issue(1, 3'd4, 5'd9, 5'd0, 0, 32'h90, 32'h900);
        edge_then_sample();
        chk("R11 jalr rd0 no write", {31'b0, ex_we}, 32'd0);
        issue(1, 3'd1, 5'd9, 5'd0, 32'h1, 0, 32'h900);
        edge_then_sample();
        chk("R11 addi rd0 no write", {31'b0, ex_we}, 32'd0);
    endtask

    task automatic t_jalr_ex_fwd();
        issue(1, 3'd1, 5'd0, 5'd6, 32'hABC, 0, 0);
        edge_then_sample();
        issue(1, 3'd4, 5'd6, 5'd7, 0, 32'h40, 32'h1);
        chk("R9 no stall on alu dep", {31'b0, stall}, 32'd0);
        chk("R9 target from EX", id_jump_target, 32'hABC);
        edge_then_sample();
        chk("R9 link after fwd", ex_result, 32'h48);
        chk("R8 dest rd", {27'b0, ex_dest}, 32'd7);
        issue(0, 3'd0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1;
                t_reset();
                @(negedge clk);
                rst_n = 1'b1;
                t_priority();
                t_zero();
                t_load_jalr();
                t_jal_bal();
                t_jr_and_r0();
                t_jalr_ex_fwd();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule